// File: doc/BRIEF.md
# Pin-to-Resource Interrupt Router

This block takes eight general-purpose input pins and lets each one drive one internal resource: the clock input of one of two counters, or one of two interrupt lines, qualified by a rising or a falling edge. Each pin has its own 3-bit route code. Every pin passes through a two-flop synchroniser before it is used. When several pins pick the same resource, their contributions are merged by OR.

A byte-wide register port holds the route codes, two per byte, and a direction byte. A direction bit only turns a pin's output enable on while that pin is left unrouted. The port is a plain address/data/strobe interface with no back-pressure. A write takes effect at the next clock edge, and reads are combinational from the address. The pins and the four resource outputs carry levels and pulses, not a stream, so they need no valid/ready handshake.

Top module: `pin_route_hub`

## Requirements
- R1: After reset every route code and direction bit is zero, so all pin_oe bits, the counter outputs, the interrupt outputs and every register read are zero.
- R2: Byte address a (0 to 3) holds the route code of pin 2a in bits [2:0] and of pin 2a+1 in bits [6:4]. Bits 3 and 7 read as zero. Address 4 holds the direction byte, with bit n belonging to pin n. Reads of any other address return zero, and writes to them change nothing.
- R3: Route code 2 feeds the pin to cnt0_clk and code 3 feeds it to cnt1_clk. Each output is a level equal to the OR of the synchronised levels of its pins. It follows a pin change after two clock edges and is 0 when no pin is routed to it.
- R4: Route code 4 (irq0) and code 5 (irq1) select rising-edge detection. A low-to-high change on the pin gives a one-cycle pulse that starts after the second clock edge.
- R5: Route code 6 (irq0) and code 7 (irq1) select falling-edge detection, with the same timing as R4. An edge in the other direction gives no pulse.
- R6: Pins that select the same resource are ORed. Simultaneous qualifying edges on several pins give a single one-cycle pulse.
- R7: Route code 0 (unrouted) and code 1 (reserved) contribute to no resource output.
- R8: pin_oe[n] is 1 exactly when pin n has route code 0 and direction bit n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| cnt0_clk | output | 1 | Merged clock level for counter 0 |
| cnt1_clk | output | 1 | Merged clock level for counter 1 |
| irq0_pulse | output | 1 | One-cycle interrupt 0 request |
| irq1_pulse | output | 1 | One-cycle interrupt 1 request |

## Verification
A corrupted route code is visible at once on reg_rdata and pin_oe. It also sends the next pin transition to the wrong resource output two edges later. A stuck synchroniser or previous-sample flop shows up as a missing or doubled interrupt pulse, or as a counter level that lags, in the third cycle after a pin change. The stimulus table changes pins in both directions under every route code, and the directed tests cover reset, readback masking and the output-enable rule.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 3'd0,
    SEL_RSVD = 3'd1,
    SEL_CNT0 = 3'd2,
    SEL_CNT1 = 3'd3,
    SEL_I0R  = 3'd4,
    SEL_I1R  = 3'd5,
    SEL_I0F  = 3'd6,
    SEL_I1F  = 3'd7
  } route_sel_e;
endpackage

// File: rtl/pr_cfg_regs.sv
module pr_cfg_regs
  import pr_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_PINS-1:0][SEL_W-1:0]   sel,
  output logic [NUM_PINS-1:0]              dir
);
  localparam int PER_BYTE   = 2;
  localparam int SLOT_W     = DATA_W / PER_BYTE;
  localparam int SEL_BYTES  = NUM_PINS / PER_BYTE;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(SEL_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      dir <= '0;
    end else if (wr) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (addr == ADDR_W'(p / PER_BYTE))
          sel[p] <= wdata[(p % PER_BYTE)*SLOT_W +: SEL_W];
      end
      if (addr == DIR_ADDR)
        dir <= wdata[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < SEL_BYTES; b++) begin
      if (addr == ADDR_W'(b)) begin
        for (int k = 0; k < PER_BYTE; k++)
          rdata[k*SLOT_W +: SEL_W] = sel[b*PER_BYTE + k];
      end
    end
    if (addr == DIR_ADDR)
      rdata[NUM_PINS-1:0] = dir;
  end
endmodule

// File: rtl/pr_pin_sync.sv
module pr_pin_sync #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_async,
  output logic [NUM_PINS-1:0] lvl,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] fall
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], pin_async[p]};
        prev  <= chain[SYNC_STAGES-1];
      end
    end

    assign lvl[p]  = chain[SYNC_STAGES-1];
    assign rise[p] = chain[SYNC_STAGES-1] & ~prev;
    assign fall[p] = ~chain[SYNC_STAGES-1] & prev;
  end
endmodule

// File: rtl/pr_merge.sv
module pr_merge
  import pr_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0][SEL_W-1:0] sel,
  input  logic [NUM_PINS-1:0]            lvl,
  input  logic [NUM_PINS-1:0]            rise,
  input  logic [NUM_PINS-1:0]            fall,
  output logic                           cnt0,
  output logic                           cnt1,
  output logic                           irq0,
  output logic                           irq1
);
  always_comb begin
    cnt0 = 1'b0;
    cnt1 = 1'b0;
    irq0 = 1'b0;
    irq1 = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      case (route_sel_e'(sel[p]))
        SEL_CNT0: cnt0 = cnt0 | lvl[p];
        SEL_CNT1: cnt1 = cnt1 | lvl[p];
        SEL_I0R:  irq0 = irq0 | rise[p];
        SEL_I1R:  irq1 = irq1 | rise[p];
        SEL_I0F:  irq0 = irq0 | fall[p];
        SEL_I1F:  irq1 = irq1 | fall[p];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pin_route_hub.sv
module pin_route_hub
  import pr_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                cnt0_clk,
  output logic                cnt1_clk,
  output logic                irq0_pulse,
  output logic                irq1_pulse
);
  logic [NUM_PINS-1:0][SEL_W-1:0] sel_w;
  logic [NUM_PINS-1:0]            dir_w;
  logic [NUM_PINS-1:0]            lvl_w, rise_w, fall_w;

  pr_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .sel(sel_w), .dir(dir_w)
  );

  pr_pin_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
    .lvl(lvl_w), .rise(rise_w), .fall(fall_w)
  );

  pr_merge #(.NUM_PINS(NUM_PINS)) u_merge (
    .sel(sel_w), .lvl(lvl_w), .rise(rise_w), .fall(fall_w),
    .cnt0(cnt0_clk), .cnt1(cnt1_clk), .irq0(irq0_pulse), .irq1(irq1_pulse)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assign pin_oe[p] = dir_w[p] & (sel_w[p] == SEL_NONE);
  end
endmodule

// File: rtl/pr_route_checker.sv
module pr_route_checker
  import pr_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reg_wr,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [DATA_W-1:0]              reg_wdata,
  input logic [DATA_W-1:0]              reg_rdata,
  input logic [NUM_PINS-1:0]            pin_oe,
  input logic                           cnt0_clk,
  input logic                           irq0_pulse,
  input logic [NUM_PINS-1:0][SEL_W-1:0] sel,
  input logic [NUM_PINS-1:0]            dir
);
  logic any_c0, any_i0;
  logic [NUM_PINS-1:0] plain;

  always_comb begin
    any_c0 = 1'b0;
    any_i0 = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      any_c0   = any_c0 | (sel[p] == 3'd2);
      any_i0   = any_i0 | (sel[p] == 3'd4) | (sel[p] == 3'd6);
      plain[p] = (sel[p] == 3'd0);
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(NUM_PINS/2)) |=> dir == $past(reg_wdata[NUM_PINS-1:0]));

  // R2
  pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < ADDR_W'(NUM_PINS/2)) |-> (reg_rdata[3] == 1'b0 && reg_rdata[7] == 1'b0));

  // R3
  cnt0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_c0 |-> !cnt0_clk);

  // R4
  irq0_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq0_pulse |-> any_i0);

  // R8
  oe_plain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~(plain & dir)) == '0);
endmodule

bind pin_route_hub pr_route_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .pin_oe(pin_oe), .cnt0_clk(cnt0_clk), .irq0_pulse(irq0_pulse),
  .sel(sel_w), .dir(dir_w)
);

// File: tb/test_pin_route_hub.sv
module test_pin_route_hub;
  localparam int CLK_P = 10;
  localparam int NV    = 12;

  // {cfg bytes 3..0, pins before, pins after, {c0,c1,i0,i1} pulse cycle, same one cycle later}
  localparam logic [55:0] VEC [NV] = '{
    {32'h00000002, 8'h00, 8'h01, 4'b1000, 4'b1000},  // R3 cnt0
    {32'h00000030, 8'h00, 8'h02, 4'b0100, 4'b0100},  // R3 cnt1
    {32'h00000400, 8'h00, 8'h04, 4'b0010, 4'b0000},  // R4 irq0 rise
    {32'h00005000, 8'h00, 8'h08, 4'b0001, 4'b0000},  // R4 irq1 rise
    {32'h00060000, 8'h10, 8'h00, 4'b0010, 4'b0000},  // R5 irq0 fall
    {32'h70000000, 8'h80, 8'h00, 4'b0001, 4'b0000},  // R5 irq1 fall
    {32'h00060000, 8'h00, 8'h10, 4'b0000, 4'b0000},  // R5 wrong edge
    {32'h00200002, 8'h01, 8'h20, 4'b1000, 4'b1000},  // R6 counter OR
    {32'h00200002, 8'h21, 8'h00, 4'b0000, 4'b0000},  // R6 both low
    {32'h06000400, 8'h40, 8'h04, 4'b0010, 4'b0000},  // R6 merged pulse
    {32'h11111111, 8'h00, 8'hFF, 4'b0000, 4'b0000},  // R7 reserved
    {32'h00007523, 8'h08, 8'h07, 4'b1101, 4'b1100}   // R3 R4 R5 mixed
  };

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, pin_in = '0, pin_oe;
  logic cnt0_clk, cnt1_clk, irq0_pulse, irq1_pulse;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pin_route_hub i_pin_route_hub (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_oe(pin_oe), .cnt0_clk(cnt0_clk),
    .cnt1_clk(cnt1_clk), .irq0_pulse(irq0_pulse), .irq1_pulse(irq1_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 check(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  function automatic logic [3:0] outs();
    return {cnt0_clk, cnt1_clk, irq0_pulse, irq1_pulse};
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 oe", {24'h0, pin_oe}, 32'h0);
    check("R1 outputs", {28'h0, outs()}, 32'h0);
    for (int a = 0; a < 5; a++) rd_check("R1 regs", 3'(a), 8'h00);

    // table walk
    for (int v = 0; v < NV; v++) begin
      for (int b = 0; b < 4; b++) wr(3'(b), VEC[v][24 + b*8 +: 8]);
      pin_in = VEC[v][23:16];
      repeat (4) @(negedge clk);
      pin_in = VEC[v][15:8];
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R3-R7 vec%0d pulse", v), {28'h0, outs()}, {28'h0, VEC[v][7:4]});
      @(negedge clk);
      check($sformatf("R4 vec%0d after", v), {28'h0, outs()}, {28'h0, VEC[v][3:0]});
    end
    pin_in = 8'h00;

    // R2 readback masking and unmapped address
    wr(3'd0, 8'hFF);
    rd_check("R2 mask", 3'd0, 8'h77);
    wr(3'd1, 8'h5A);
    rd_check("R2 byte1", 3'd1, 8'h52);
    wr(3'd4, 8'h3C);
    rd_check("R2 dir", 3'd4, 8'h3C);
    wr(3'd5, 8'hFF);
    rd_check("R2 unmapped read", 3'd5, 8'h00);
    rd_check("R2 unmapped write dir", 3'd4, 8'h3C);
    rd_check("R2 unmapped write sel", 3'd0, 8'h77);

    // R8 output enable
    for (int b = 0; b < 4; b++) wr(3'(b), 8'h00);
    wr(3'd4, 8'hA5);
    @(negedge clk);
    check("R8 all plain", {24'h0, pin_oe}, 32'hA5);
    wr(3'd0, 8'h02);
    @(negedge clk);
    check("R8 routed pin0", {24'h0, pin_oe}, 32'hA4);
    wr(3'd2, 8'h10);
    @(negedge clk);
    check("R8 reserved pin5", {24'h0, pin_oe}, 32'h84);

    // R1 reset in mid-run
    pin_in = 8'h01;
    repeat (3) @(negedge clk);
    check("R3 before reset", {28'h0, outs()}, 32'h8);
    rst_n = 1'b0;
    #1;
    check("R1 oe after reset", {24'h0, pin_oe}, 32'h0);
    check("R1 outs after reset", {28'h0, outs()}, 32'h0);
    reg_addr = 3'd4;
    #1 check("R1 dir after reset", {24'h0, reg_rdata}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule